// File: doc/BRIEF.md
# Participating Input Hold Gate

This block sits between a bank of input pins and the logic that consumes them. It saves power by stopping pin activity from reaching the internal logic. Each pin has its own participate flag. One control line is shared by the whole bank. While that control is high, every participating pin is replaced by a held copy of its earlier value. Toggling on the pin then no longer propagates inward. Pins that do not participate always pass straight through.

The control can come from two places, chosen by a select input. One is a dedicated control pin. The other is any internal signal, such as a counter bit or an FSM state decode. Whichever control is selected is also driven onto a monitor output so that it can be observed from outside.

The held value is refreshed on every rising clock edge at which the control is low. While the control is low, the gated output is the live pin value, with no register in its path. An active-low asynchronous reset clears all held values to zero.

Top module: `input_hold_gate`

## Requirements
- R1: While rst_ni is low, every held value is zero. If the control is high from reset onward, a participating output reads 0 until the first rising edge at which the control is low.
- R2: While the selected control is low, gated_o equals pin_i in the same cycle, with no added clock delay.
- R3: A pin whose participate_i bit is 0 drives gated_o with its live pin_i value at all times, whatever the control level.
- R4: While the control is high, a participating output shows the pin value sampled at the last rising clock edge at which the control was low. Later pin activity leaves that output unchanged.
- R5: ctrl_src_sel_i = 0 selects ctrl_pin_i as the control, and ctrl_src_sel_i = 1 selects ctrl_logic_i. The control source that is not selected has no effect on gated_o or ctrl_mon_o.
- R6: ctrl_mon_o always equals the currently selected control value.
- R7: Participation is decided per pin. Changing one participate_i bit changes the behaviour of that pin only.
- R8: In the cycle in which the control falls, every output again follows its live pin value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the hold registers |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the held values |
| pin_i | input | NUM_PINS | Raw input pins |
| participate_i | input | NUM_PINS | Per-pin gating opt-in; 1 means the pin takes part in gating |
| ctrl_src_sel_i | input | 1 | Control source select: 0 = control pin, 1 = internal logic |
| ctrl_pin_i | input | 1 | Control from the dedicated pin |
| ctrl_logic_i | input | 1 | Control from internal logic |
| gated_o | output | NUM_PINS | Pin values as seen by the internal logic |
| ctrl_mon_o | output | 1 | Mirror of the selected control |

## Verification
A held value that is wrong, or captured one edge too late, only appears at gated_o once the control is high for a participating pin. It shows in the first cycle after the control rises, because the bench changes the pins in that same cycle. A wrong source select or wrong participation shows at once as a mismatch against the live pin or the monitor output. The reference model is compared against every output on every clock.

// File: rtl/input_hold_gate_pkg.sv
package input_hold_gate_pkg;
  typedef enum logic {
    CTRL_FROM_PIN   = 1'b0,
    CTRL_FROM_LOGIC = 1'b1
  } ctrl_src_e;
endpackage

// File: rtl/ihg_ctrl_select.sv
module ihg_ctrl_select
  import input_hold_gate_pkg::*;
(
  input  logic      sel_i,
  input  logic      ctrl_pin_i,
  input  logic      ctrl_logic_i,
  output logic      ctrl_o
);
  ctrl_src_e src;
  assign src = ctrl_src_e'(sel_i);

  always_comb begin
    unique case (src)
      CTRL_FROM_LOGIC: ctrl_o = ctrl_logic_i;
      default:         ctrl_o = ctrl_pin_i;
    endcase
  end
endmodule

// File: rtl/ihg_hold_cell.sv
module ihg_hold_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic part_i,
  input  logic pin_i,
  output logic out_o
);
  logic held_q;

  // refresh while open; freezes at the last open edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= 1'b0;
    else if (!gate_i) held_q <= pin_i;
  end

  assign out_o = (gate_i && part_i) ? held_q : pin_i;
endmodule

// File: rtl/input_hold_gate.sv
module input_hold_gate #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] participate_i,
  input  logic                ctrl_src_sel_i,
  input  logic                ctrl_pin_i,
  input  logic                ctrl_logic_i,
  output logic [NUM_PINS-1:0] gated_o,
  output logic                ctrl_mon_o
);
  logic gate;

  ihg_ctrl_select u_sel (
    .sel_i        (ctrl_src_sel_i),
    .ctrl_pin_i   (ctrl_pin_i),
    .ctrl_logic_i (ctrl_logic_i),
    .ctrl_o       (gate)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cell
    ihg_hold_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gate_i (gate),
      .part_i (participate_i[g]),
      .pin_i  (pin_i[g]),
      .out_o  (gated_o[g])
    );
  end

  assign ctrl_mon_o = gate;
endmodule

// File: rtl/input_hold_gate_chk.sv
module input_hold_gate_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] participate_i,
  input logic                ctrl_src_sel_i,
  input logic                ctrl_pin_i,
  input logic                ctrl_logic_i,
  input logic [NUM_PINS-1:0] gated_o,
  input logic                ctrl_mon_o
);
  assert_reset_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_ni) && ctrl_mon_o) |-> ((gated_o & participate_i) == '0));

  assert_open_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_mon_o |-> (gated_o == pin_i));

  assert_nonpart_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gated_o ^ pin_i) & ~participate_i) == '0);

  assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_mon_o && $past(ctrl_mon_o) && $stable(participate_i))
      |-> $stable(gated_o & participate_i));

  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_mon_o) && $past(rst_ni))
      |-> ((gated_o & participate_i) == ($past(pin_i) & participate_i)));

  assert_src_pin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_src_sel_i |-> (ctrl_mon_o == ctrl_pin_i));

  assert_src_logic_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_src_sel_i |-> (ctrl_mon_o == ctrl_logic_i));
endmodule

bind input_hold_gate input_hold_gate_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pin_i          (pin_i),
  .participate_i  (participate_i),
  .ctrl_src_sel_i (ctrl_src_sel_i),
  .ctrl_pin_i     (ctrl_pin_i),
  .ctrl_logic_i   (ctrl_logic_i),
  .gated_o        (gated_o),
  .ctrl_mon_o     (ctrl_mon_o)
);

// File: tb/input_hold_gate_test.sv
module input_hold_gate_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic [N-1:0] part = '0;
  logic         sel = 1'b0;
  logic         cpin = 1'b0;
  logic         clog = 1'b0;
  logic [N-1:0] gated;
  logic         mon;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [N-1:0] m_hold = '0;

  always #5 clk = ~clk;

  input_hold_gate #(.NUM_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .participate_i(part),
    .ctrl_src_sel_i(sel), .ctrl_pin_i(cpin), .ctrl_logic_i(clog),
    .gated_o(gated), .ctrl_mon_o(mon)
  );

  function automatic logic m_ctrl();
    return sel ? clog : cpin;
  endfunction

  function automatic logic [N-1:0] m_out();
    if (m_ctrl()) return (m_hold & part) | (pin & ~part);
    return pin;
  endfunction

  // inputs already applied; compare, then clock and update model
  task automatic step(input string tag);
    #1;
    checks++;
    if (gated !== m_out() || mon !== m_ctrl()) begin
      failures++;
      $display("FAIL %s: gated=%h mon=%b expected gated=%h mon=%b",
               tag, gated, mon, m_out(), m_ctrl());
    end
    @(posedge clk);
    if (!rst_n) m_hold = '0;
    else if (!m_ctrl()) m_hold = pin;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset with gate high, participating pins read held zero
    cpin = 1'b1; pin = '1; part = '1;
    step("R1"); step("R1");
    rst_n = 1'b1;
    step("R1"); step("R1");
    // R2: open gate, pass through
    cpin = 1'b0;
    for (int i = 0; i < 10; i++) begin
      pin = N'($urandom);
      step("R2");
    end
    // R4 / R3: capture then freeze under pin toggling, mixed participation
    part = 8'hA5;
    pin = 8'h3C; step("R4");
    cpin = 1'b1;
    for (int i = 0; i < 12; i++) begin
      pin = N'($urandom);
      step("R4 R3");
    end
    // R8: release
    cpin = 1'b0; pin = 8'hC3; step("R8");
    for (int i = 0; i < 4; i++) begin pin = N'($urandom); step("R8"); end
    // R5 / R6: internal logic source, control pin ignored
    sel = 1'b1; clog = 1'b0; part = '1;
    for (int i = 0; i < 8; i++) begin
      cpin = ~cpin; pin = N'($urandom); step("R5 R6");
    end
    pin = 8'h5A; step("R5");
    clog = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cpin = ~cpin; pin = N'($urandom); step("R5 R6");
    end
    // R7: change one participate bit while blocked
    part = 8'hFE; pin = 8'h00; step("R7");
    part = 8'h7F; pin = 8'hFF; step("R7");
    clog = 1'b0; pin = 8'h81; step("R7");
    // R6: back to pin source, gate via control pin
    sel = 1'b0; cpin = 1'b1; pin = 8'h18; step("R6");
    cpin = 1'b0; step("R8");
    // R4: gate high for long run
    pin = 8'hE7; part = '1; step("R4");
    cpin = 1'b1;
    for (int i = 0; i < 20; i++) begin pin = N'($urandom); step("R4"); end
    finish_run();
  end
endmodule